// File: doc/BRIEF.md
# Vector String Range Compare Unit

This unit classifies every element of a 128-bit string operand against a set of programmable ranges. A second 128-bit operand supplies the range bounds, taken two at a time: each even/odd pair of bound elements forms one range. A third 128-bit operand supplies a selector per bound that says which unsigned relations (equal, data below bound, data above bound) count as a pass. An element of the string belongs to a range when both bounds of that pair pass, and it is a hit when it belongs to any range. The hit can be inverted.

The unit runs one string element per clock under a start/done handshake. In index mode it returns the byte offset of the first hit, bounded by the offset of the first zero element when zero search is enabled, and stops early. In mask mode it returns a vector where every hit element is all ones, and it always evaluates every element. A two-bit condition code summarises whether a hit, a zero element, or both were found and which came first. Element widths of 8, 16 and 32 bits are supported.

Top module: `strc_range_scan`

## Requirements
- R1: `elem_size` 0, 1 and 2 select 8-, 16- and 32-bit elements, and 3 acts as 2. Elements are numbered from the most significant end. Element i starts at byte offset i times the element byte count, and byte offset 0 is bits 127:120.
- R2: Bound elements 2k and 2k+1 form range k. A string element matches range k only when both bound tests pass, and it is a hit when it matches at least one range.
- R3: A bound's selector is the most significant byte of the same-numbered element of `sel_vec`. Bit 7 passes on data equal to the bound, bit 6 passes on data below it and bit 5 passes on data above it. The comparison is unsigned, and the other selector bits have no effect.
- R4: With `invert` high, each element's hit value is complemented before it is used.
- R5: In index mode (`mask_mode` low), result[127:64] holds the smaller of the first-hit byte offset and the first-zero byte offset. Either offset is 16 when absent. result[63:0] is zero.
- R6: In index mode the scan ends on the first hit, or on reaching the first zero element, which is then not counted as a hit. `busy` is high for exactly (stop element index + 1) cycles, or for the element count if neither event occurs.
- R7: `cc` is 3 when there is no hit and no zero. It is 1 when there is a hit and no zero, and 2 when the first hit lies before the first zero. It is 0 in every other case.
- R8: In mask mode every hit element of the result is all ones and every other element is zero. Elements after a zero element are still evaluated. `busy` lasts the full element count, and `cc` uses the lowest hit offset.
- R9: With `zero_term` low, no zero element is recognised and the first-zero offset is 16.
- R10: `start` is accepted when not busy, and the operands and flags are captured at that edge. `busy` follows on the next cycle. `busy` and `done` are never high together. `start` during `busy` is ignored. `done`, `result` and `cc` hold until the next accepted start.
- R11: After reset `busy`, `done`, `result` and `cc` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a scan with the present operands |
| elem_size | input | 2 | Element width code |
| invert | input | 1 | Complement per-element hit |
| mask_mode | input | 1 | 1: per-element mask result, 0: index result |
| zero_term | input | 1 | Enable zero-element detection |
| str_vec | input | 128 | String operand |
| bound_vec | input | 128 | Range bounds, paired even/odd |
| sel_vec | input | 128 | Per-bound relation selectors |
| busy | output | 1 | Scan in progress |
| done | output | 1 | Result valid |
| result | output | 128 | Index or mask result |
| cc | output | 2 | Condition code |

## Verification
Directed strings with a lowercase-letter range separate index from mask output and show the effect of inversion. A zero placed before, after and on a hit element tells the four condition codes apart and shows that the zero element itself is never reported as a hit in index mode. Bounds with only one selector bit set, at all three element widths and with the size code 3, show which relation and which pairing is used. Randomised operands with small byte values give dense equalities and zeros, and they also re-pulse `start` and change the operands mid-scan to show that the captured values are the ones used.

// File: rtl/strc_pkg.sv
package strc_pkg;
  localparam int VEC_W     = 128;
  localparam int VEC_BYTES = VEC_W / 8;
  localparam int IDX_W     = $clog2(VEC_BYTES);
  localparam int OFF_W     = IDX_W + 1;
  localparam int MAX_PAIRS = VEC_BYTES / 2;
  localparam int MAX_EW    = 32;
  localparam int SEL_EQ    = 7;
  localparam int SEL_LT    = 6;
  localparam int SEL_GT    = 5;

  typedef logic [1:0]       esz_t;
  typedef logic [VEC_W-1:0] vec_t;
  typedef logic [OFF_W-1:0] off_t;
  typedef logic [IDX_W-1:0] idx_t;
  typedef enum logic [1:0] {ST_IDLE, ST_RUN, ST_DONE} scan_st_t;

  function automatic esz_t esz_fix(esz_t e);
    return (e == 2'd3) ? 2'd2 : e;
  endfunction

  function automatic int elem_cnt(esz_t e);
    return VEC_BYTES >> esz_fix(e);
  endfunction

  function automatic logic [MAX_EW-1:0] elem_get(vec_t v, esz_t e, int i);
    int w = 8 << esz_fix(e);
    vec_t s;
    if (i >= elem_cnt(e)) return '0;
    s = v >> (VEC_W - (i + 1) * w);
    s = s & ({VEC_W{1'b1}} >> (VEC_W - w));
    return s[MAX_EW-1:0];
  endfunction

  function automatic logic [7:0] ctrl_get(vec_t v, esz_t e, int i);
    int off = i << esz_fix(e);
    if (i >= elem_cnt(e)) return 8'h00;
    return v[VEC_W-1-8*off -: 8];
  endfunction

  function automatic vec_t elem_ones(esz_t e, int i);
    int w = 8 << esz_fix(e);
    return ({VEC_W{1'b1}} >> (VEC_W - w)) << (VEC_W - (i + 1) * w);
  endfunction

  function automatic logic bound_ok(logic [MAX_EW-1:0] d, logic [MAX_EW-1:0] b,
                                    logic [7:0] sel);
    if (d < b) return sel[SEL_LT];
    if (d > b) return sel[SEL_GT];
    return sel[SEL_EQ];
  endfunction

  function automatic logic [1:0] cc_of(off_t fm, off_t fz);
    off_t none = off_t'(VEC_BYTES);
    if (fm == none && fz == none) return 2'd3;
    if (fz == none) return 2'd1;
    if (fm < fz) return 2'd2;
    return 2'd0;
  endfunction
endpackage

// File: rtl/strc_pair_match.sv
module strc_pair_match
  import strc_pkg::*;
#(
  parameter int PAIRS = MAX_PAIRS
) (
  input  esz_t              esz,
  input  logic [MAX_EW-1:0] data,
  input  vec_t              bounds,
  input  vec_t              ctrl,
  output logic              hit
);
  logic [PAIRS-1:0] pair_hit;

  for (genvar p = 0; p < PAIRS; p++) begin : g_pair
    localparam int LO = 2 * p;
    localparam int HI = 2 * p + 1;
    assign pair_hit[p] = (HI < elem_cnt(esz)) &&
                         bound_ok(data, elem_get(bounds, esz, LO), ctrl_get(ctrl, esz, LO)) &&
                         bound_ok(data, elem_get(bounds, esz, HI), ctrl_get(ctrl, esz, HI));
  end

  assign hit = |pair_hit;
endmodule

// File: rtl/strc_zero_find.sv
module strc_zero_find
  import strc_pkg::*;
(
  input  esz_t esz,
  input  logic enable,
  input  vec_t str,
  output off_t first_zero
);
  always_comb begin
    first_zero = off_t'(VEC_BYTES);
    if (enable) begin
      for (int i = VEC_BYTES - 1; i >= 0; i--) begin
        if (i < elem_cnt(esz) && elem_get(str, esz, i) == '0)
          first_zero = off_t'(i << esz_fix(esz));
      end
    end
  end
endmodule

// File: rtl/strc_scan_ctrl.sv
module strc_scan_ctrl
  import strc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  esz_t esz,
  input  logic stop_early,
  output idx_t idx,
  output logic busy,
  output logic done,
  output logic accept,
  output logic finish
);
  scan_st_t st_q;
  logic     last;

  assign last   = (int'(idx) == elem_cnt(esz) - 1);
  assign busy   = (st_q == ST_RUN);
  assign done   = (st_q == ST_DONE);
  assign accept = start && !busy;
  assign finish = busy && (stop_early || last);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
      idx  <= '0;
    end else if (accept) begin
      st_q <= ST_RUN;
      idx  <= '0;
    end else if (finish) begin
      st_q <= ST_DONE;
    end else if (busy) begin
      idx <= idx + 1'b1;
    end
  end
endmodule

// File: rtl/strc_range_scan.sv
module strc_range_scan
  import strc_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [1:0]   elem_size,
  input  logic         invert,
  input  logic         mask_mode,
  input  logic         zero_term,
  input  logic [127:0] str_vec,
  input  logic [127:0] bound_vec,
  input  logic [127:0] sel_vec,
  output logic         busy,
  output logic         done,
  output logic [127:0] result,
  output logic [1:0]   cc
);
  localparam int HALF_W = VEC_W / 2;

  vec_t        str_q, bound_q, sel_q;
  esz_t        esz_q;
  logic        inv_q, mode_mask_q, zs_q;
  idx_t        idx;
  logic        accept, finish, stop_early;
  off_t        first_zero, cur_off, fm_q, fm_nx, best_off;
  logic        raw_hit, elem_hit, at_zero, hit_evt;
  vec_t        mask_q, mask_nx, result_q;
  logic [1:0]  cc_q;

  strc_scan_ctrl u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .start      (start),
    .esz        (esz_q),
    .stop_early (stop_early),
    .idx        (idx),
    .busy       (busy),
    .done       (done),
    .accept     (accept),
    .finish     (finish)
  );

  strc_zero_find u_zero (
    .esz        (esz_q),
    .enable     (zs_q),
    .str        (str_q),
    .first_zero (first_zero)
  );

  strc_pair_match #(.PAIRS(MAX_PAIRS)) u_match (
    .esz    (esz_q),
    .data   (elem_get(str_q, esz_q, int'(idx))),
    .bounds (bound_q),
    .ctrl   (sel_q),
    .hit    (raw_hit)
  );

  assign cur_off    = off_t'(int'(idx) << esz_fix(esz_q));
  assign elem_hit   = raw_hit ^ inv_q;
  assign at_zero    = (cur_off == first_zero);
  assign stop_early = !mode_mask_q && (at_zero || elem_hit);
  assign hit_evt    = busy && elem_hit && !(!mode_mask_q && at_zero);

  assign fm_nx    = (hit_evt && fm_q == off_t'(VEC_BYTES)) ? cur_off : fm_q;
  assign mask_nx  = (hit_evt && mode_mask_q) ? (mask_q | elem_ones(esz_q, int'(idx))) : mask_q;
  assign best_off = (fm_nx < first_zero) ? fm_nx : first_zero;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      str_q       <= '0;
      bound_q     <= '0;
      sel_q       <= '0;
      esz_q       <= '0;
      inv_q       <= 1'b0;
      mode_mask_q <= 1'b0;
      zs_q        <= 1'b0;
      fm_q        <= off_t'(VEC_BYTES);
      mask_q      <= '0;
      result_q    <= '0;
      cc_q        <= '0;
    end else if (accept) begin
      str_q       <= str_vec;
      bound_q     <= bound_vec;
      sel_q       <= sel_vec;
      esz_q       <= elem_size;
      inv_q       <= invert;
      mode_mask_q <= mask_mode;
      zs_q        <= zero_term;
      fm_q        <= off_t'(VEC_BYTES);
      mask_q      <= '0;
      result_q    <= '0;
      cc_q        <= '0;
    end else if (busy) begin
      fm_q   <= fm_nx;
      mask_q <= mask_nx;
      if (finish) begin
        result_q <= mode_mask_q ? mask_nx
                                : {{(HALF_W-OFF_W){1'b0}}, best_off, {HALF_W{1'b0}}};
        cc_q     <= cc_of(fm_nx, first_zero);
      end
    end
  end

  assign result = result_q;
  assign cc     = cc_q;
endmodule

// File: rtl/strc_range_scan_chk.sv
module strc_range_scan_chk (
  input logic         clk,
  input logic         rst_n,
  input logic         start,
  input logic         busy,
  input logic         done,
  input logic [127:0] result,
  input logic [1:0]   cc,
  input logic         mode_mask_q,
  input logic         hit_evt,
  input logic         finish
);
  a_r10_busy_done_excl: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy && done));

  a_r10_hold: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done && $stable(result) && $stable(cc));

  a_r10_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(start));

  a_r5_index_format: assert property (@(posedge clk) disable iff (!rst_n)
    done && !mode_mask_q |-> result[63:0] == 64'd0 && result[127:64] <= 64'd16);

  a_r7_cc3_iff_none: assert property (@(posedge clk) disable iff (!rst_n)
    done && !mode_mask_q |-> ((cc == 2'd3) == (result[127:64] == 64'd16)));

  a_r6_stop_on_hit: assert property (@(posedge clk) disable iff (!rst_n)
    busy && !mode_mask_q && hit_evt |-> finish);
endmodule

bind strc_range_scan strc_range_scan_chk u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .start       (start),
  .busy        (busy),
  .done        (done),
  .result      (result),
  .cc          (cc),
  .mode_mask_q (mode_mask_q),
  .hit_evt     (hit_evt),
  .finish      (finish)
);

// File: tb/strc_range_scan_tb.sv
module strc_range_scan_tb_top;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [1:0]   elem_size = 2'd0;
  logic         invert = 1'b0, mask_mode = 1'b0, zero_term = 1'b0;
  logic [127:0] str_vec = '0, bound_vec = '0, sel_vec = '0;
  logic         busy, done;
  logic [127:0] result;
  logic [1:0]   cc;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;

  always #2.5 clk = ~clk;

  strc_range_scan dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .elem_size(elem_size),
    .invert(invert), .mask_mode(mask_mode), .zero_term(zero_term),
    .str_vec(str_vec), .bound_vec(bound_vec), .sel_vec(sel_vec),
    .busy(busy), .done(done), .result(result), .cc(cc)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      n_fail++;
      n_checks++;
      $display("FAIL watchdog actual=%0d expected=<150000", cyc);
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  // reference model
  function automatic int nbytes(logic [1:0] es);
    if (es == 2'd0) return 1;
    if (es == 2'd1) return 2;
    return 4;
  endfunction

  function automatic logic [31:0] rd(logic [127:0] v, int off, int nb);
    logic [31:0] x = 32'd0;
    for (int b = 0; b < nb; b++) x = {x[23:0], v[127-8*(off+b) -: 8]};
    return x;
  endfunction

  function automatic bit pass(logic [31:0] d, logic [31:0] bd, logic [7:0] s);
    return (d < bd && s[6]) || (d > bd && s[5]) || (d == bd && s[7]);
  endfunction

  task automatic model(input logic [1:0] es, input bit inv, input bit mm, input bit zs,
                       input logic [127:0] a, input logic [127:0] b, input logic [127:0] c,
                       output logic [127:0] res, output logic [1:0] ccx, output int steps);
    int nb = nbytes(es);
    int n = 16 / nb;
    int fz = 16;
    int fm = 16;
    logic [127:0] msk = '0;
    steps = n;
    if (zs)
      for (int i = 0; i < n; i++)
        if (rd(a, i*nb, nb) == 32'd0) begin fz = i*nb; break; end
    for (int i = 0; i < n; i++) begin
      int off = i*nb;
      bit m = 1'b0;
      if (!mm && off == fz) begin steps = i + 1; break; end
      for (int j = 0; j < n; j += 2)
        if (pass(rd(a, off, nb), rd(b, j*nb, nb), c[127-8*j*nb -: 8]) &&
            pass(rd(a, off, nb), rd(b, (j+1)*nb, nb), c[127-8*(j+1)*nb -: 8]))
          m = 1'b1;
      m = m ^ inv;
      if (m) begin
        if (mm) begin
          for (int k = 0; k < nb; k++) msk[127-8*(off+k) -: 8] = 8'hFF;
          if (fm == 16) fm = off;
        end else begin
          fm = off;
          steps = i + 1;
          break;
        end
      end
    end
    if (mm) res = msk;
    else res = {64'(fm < fz ? fm : fz), 64'd0};
    if (fm == 16 && fz == 16) ccx = 2'd3;
    else if (fz == 16) ccx = 2'd1;
    else if (fm < fz) ccx = 2'd2;
    else ccx = 2'd0;
  endtask

  task automatic run(input string tag, input logic [1:0] es, input bit inv, input bit mm,
                     input bit zs, input logic [127:0] a, input logic [127:0] b,
                     input logic [127:0] c);
    logic [127:0] er;
    logic [1:0]   ec;
    int           st;
    string        rq = mm ? "R8" : "R5";
    string        sq = mm ? "R8" : "R6";
    model(es, inv, mm, zs, a, b, c, er, ec, st);
    @(negedge clk);
    elem_size = es; invert = inv; mask_mode = mm; zero_term = zs;
    str_vec = a; bound_vec = b; sel_vec = c; start = 1'b1;
    for (int k = 1; k <= st; k++) begin
      @(negedge clk);
      if (k == 1) begin
        str_vec = ~a; bound_vec = {b[63:0], b[127:64]}; invert = ~inv;
        mask_mode = ~mm; elem_size = es + 2'd1;
      end else start = 1'b0;
      chk(busy && !done, sq, {tag, " busy during scan"}, 128'({busy, done}), 128'b10);
    end
    @(negedge clk);
    start = 1'b0;
    chk(done && !busy, sq, {tag, " done after scan length"}, 128'({busy, done}), 128'b01);
    chk(result === er, rq, {tag, " result"}, result, er);
    chk(cc === ec, "R7", {tag, " cc"}, 128'(cc), 128'(ec));
    @(negedge clk);
    chk(done && result === er && cc === ec, "R10", {tag, " hold"}, result, er);
  endtask

  function automatic logic [127:0] rnd_vec(int lim);
    logic [127:0] v;
    for (int i = 0; i < 16; i++) v[8*i +: 8] = 8'($urandom_range(0, lim));
    return v;
  endfunction

  localparam logic [127:0] HELLO = 128'h48454C4C4F776F726C64212121212121;
  localparam logic [127:0] AZ_B  = 128'h617A0000000000000000000000000000;
  localparam logic [127:0] AZ_C  = 128'hA0C00000000000000000000000000000;

  initial begin
    repeat (3) @(negedge clk);
    chk(!busy && !done && result == '0 && cc == 2'd0, "R11", "reset state",
        {busy, done, cc, result[124:0]}, '0);
    rst_n = 1'b1;

    run("R2 lowercase range", 2'd0, 1'b0, 1'b0, 1'b0, HELLO, AZ_B, AZ_C);
    run("R4 inverted range", 2'd0, 1'b1, 1'b0, 1'b0, HELLO, AZ_B, AZ_C);
    run("R4 inverted mask", 2'd0, 1'b1, 1'b1, 1'b0, HELLO, AZ_B, AZ_C);
    run("R8 mask lowercase", 2'd0, 1'b0, 1'b1, 1'b0, HELLO, AZ_B, AZ_C);
    run("R6 zero before hit", 2'd0, 1'b0, 1'b0, 1'b1,
        128'h48450000776F726C6421212121212121, AZ_B, AZ_C);
    run("R7 zero after hit", 2'd0, 1'b0, 1'b0, 1'b1,
        128'h4845776F000000000000000000000000, AZ_B, AZ_C);
    run("R9 zero ignored", 2'd0, 1'b0, 1'b0, 1'b0,
        128'h48450000776F726C6421212121212121, AZ_B, AZ_C);
    run("R7 nothing found", 2'd0, 1'b0, 1'b0, 1'b1,
        128'h41414141414141414141414141414141, AZ_B, AZ_C);
    run("R6 zero element in range", 2'd0, 1'b0, 1'b0, 1'b1,
        128'h41420043414141414141414141414141,
        128'h00100000000000000000000000000000, AZ_C);
    run("R8 zero element in range", 2'd0, 1'b0, 1'b1, 1'b1,
        128'h41420043004141414141414141414141,
        128'h00100000000000000000000000000000, AZ_C);
    run("R3 equal only", 2'd0, 1'b0, 1'b0, 1'b0, HELLO,
        128'h4C4C0000000000000000000000000000,
        128'h9F9F0000000000000000000000000000);
    run("R3 above only", 2'd0, 1'b0, 1'b1, 1'b0, HELLO,
        128'h6F000000000000000000000000000000,
        128'h3F3F0000000000000000000000000000);
    run("R1 halfword", 2'd1, 1'b0, 1'b1, 1'b1,
        128'h00410042004300000044004500460047,
        128'h00420044000000000000000000000000,
        128'hA000C000000000000000000000000000);
    run("R1 word", 2'd2, 1'b0, 1'b0, 1'b1,
        128'h00000100000002000000000000000300,
        128'h00000180000003000000000000000000,
        128'hA0000000C00000000000000000000000);
    run("R1 size code three", 2'd3, 1'b0, 1'b1, 1'b0,
        128'h00000100000002000000000000000300,
        128'h00000180000003000000000000000000,
        128'hA0000000C00000000000000000000000);
    run("R2 second pair", 2'd1, 1'b0, 1'b0, 1'b0,
        128'h00050009000A00020001000300040006,
        128'h0000000000010003FFFF000000000000,
        128'h0000000060006000A000000000000000);

    for (int t = 0; t < 300; t++) begin
      logic [1:0] es = 2'($urandom_range(0, 3));
      run("R2 R3 random", es, 1'($urandom), 1'($urandom), 1'($urandom),
          rnd_vec(3), rnd_vec(3), rnd_vec(255));
    end

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule